// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable, small-depth synchronous SRAM. A command is sampled on one rising edge: address, read or write, load or advance, three chip selects and per-lane write enables. Its data transfer belongs to the next edge. A write takes its data from `din` on that second edge. A read puts the addressed word on `dout` combinationally during the cycle between the two edges. Because every command has the same one-cycle data offset, a write may follow a read, or a read a write, on consecutive cycles with no idle bus cycle.

A load command starts a new operation at the external address. An advance command steps an internal 2-bit beat counter, and the previous operation type continues. A burst therefore covers four words from one address. The low two address bits follow either linear order or interleaved order, chosen by a static input. An active-low clock enable freezes the whole block. A deselect starts no new operation, but the transfer already pending still completes. The data bus is represented by `din`, `dout` and a drive enable `dout_oe`, which an asynchronous output-enable input can force off at any time.

Top module: `ftzt_sram`

## Requirements
- R1: A read command sampled on an edge drives `dout_oe`=1 and `dout` = the stored word during the next cycle. A write command sampled on an edge stores `din` on the following enabled edge.
- R2: Write-then-read and read-then-write commands on consecutive cycles both complete with no idle cycle between them. A read that follows a write to the same address returns the new data.
- R3: While `clk_en_n`=1, every input except `drive_ok` is ignored. The pending operation, the beat, `dout` and `dout_oe` hold, and no word is written.
- R4: A new operation starts only when `burst_adv`=0 and `cs0_n`=0, `cs1`=1, `cs2_n`=0. A load with any chip select inactive starts nothing and writes nothing. An advance while idle also starts nothing. The transfer pending at the deselect still completes.
- R5: `dout_oe` is 0 in the cycle after a deselect and in the cycle after a write command is sampled.
- R6: With `burst_adv`=1 and an operation active, the beat counter steps by one (modulo 4) and the operation type stays the same.
- R7: With `seq_linear`=1, the low two bits of the word address in beat k are (start + k) mod 4. The upper bits stay at the start address.
- R8: With `seq_linear`=0, the low two bits of the word address in beat k are start XOR k.
- R9: Lane i (bits 9i+8..9i) of a word is written only when `lane_wen[i]`=1 in the command that owns the data cycle.
- R10: `drive_ok`=0 forces `dout_oe` to 0 at once, without waiting for a clock edge.
- R11: A synchronous reset (`rst_n`=0) leaves no operation pending, so `dout_oe`=0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low. 1 freezes the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 0 loads the address, 1 advances the burst |
| is_write | input | 1 | 1 for a write command, 0 for a read |
| addr | input | AW (8) | Word address |
| lane_wen | input | LANES (4) | Per-lane write enables, active high |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| drive_ok | input | 1 | Asynchronous output enable, active high |
| din | input | DW (36) | Write data |
| dout | output | DW (36) | Read data, valid while `dout_oe`=1 |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
Every result falls due one cycle after the command that causes it. Read data and `dout_oe` become valid in the cycle after the sampling edge. Write data is taken on the second edge and shows up later through a read, so the bench compares what it reads against a reference memory. The bench applies each command at a falling edge and checks the outputs at the next falling edge. That check belongs to the command sampled at the rising edge in between. A stalled edge is treated as the same cycle again. The asynchronous output enable is checked a few nanoseconds after it toggles in the middle of a cycle.

// File: rtl/ftzt_pkg.sv
// Package: shared types and the burst-order function for the flow-through
// zero-turnaround SRAM. Assumes a burst of exactly four beats.
package ftzt_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // Low word-address bits for a given beat: linear adds, interleaved XORs.
    function automatic logic [BEAT_W-1:0] burst_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        logic [BEAT_W-1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/ftzt_cmd_reg.sv
// Command register with burst counter. It captures a command on each enabled
// edge and holds it for the data cycle that follows.
// Assumes: clk_en_n=1 freezes every register. A load with all selects active
// starts an operation. A load otherwise idles the block. An advance steps the
// beat only while an operation is active.
module ftzt_cmd_reg
    import ftzt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic                selected,
    input  logic                burst_adv,
    input  logic                is_write,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    lane_wen,
    output logic                pend_v,
    output op_e                 pend_op,
    output logic [AW-1:0]       base,
    output logic [BEAT_W-1:0]   beat,
    output logic [LANES-1:0]    lanes
);

    // Purpose: capture a load, step a burst, or hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v  <= 1'b0;
            pend_op <= OP_RD;
            base    <= '0;
            beat    <= '0;
            lanes   <= '0;
        end else if (!clk_en_n) begin
            if (!burst_adv) begin
                if (selected) begin
                    pend_v  <= 1'b1;
                    pend_op <= is_write ? OP_WR : OP_RD;
                    base    <= addr;
                    beat    <= '0;
                    lanes   <= lane_wen;
                end else begin
                    pend_v  <= 1'b0;
                    lanes   <= '0;
                end
            end else if (pend_v) begin
                beat  <= beat + 1'b1;
                lanes <= lane_wen;
            end
        end
    end

endmodule

// File: rtl/ftzt_addr_gen.sv
// Burst address generator. It forms the word address of the current beat
// from the captured start address. Only the low two bits follow the burst
// order. Assumes AW >= 2.
module ftzt_addr_gen
    import ftzt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0]     base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              seq_linear,
    output logic [AW-1:0]     eff_addr
);

    logic [BEAT_W-1:0] low_bits;

    // Purpose: choose the linear or interleaved low bits.
    always_comb low_bits = burst_offset(base[BEAT_W-1:0], beat, seq_linear);

    generate
        if (AW > BEAT_W) begin : g_wide
            assign eff_addr = {base[AW-1:BEAT_W], low_bits};
        end else begin : g_narrow
            assign eff_addr = low_bits;
        end
    endgenerate

endmodule

// File: rtl/ftzt_array.sv
// Storage array split into byte lanes. Each lane is written on the clock
// edge when its enable is set, and read combinationally (flow-through).
// Assumes DEPTH is a power of two. The contents are not reset.
module ftzt_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    word_addr,
    input  logic [LANES-1:0] lane_mask,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] bank [DEPTH];

            // Purpose: update this lane of the addressed word.
            always_ff @(posedge clk) begin
                if (wr_en && lane_mask[g]) begin
                    bank[word_addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rdata[g*LANE_W +: LANE_W] = bank[word_addr];
        end
    endgenerate

endmodule

// File: rtl/ftzt_sram.sv
// Top of the flow-through zero-turnaround SRAM. A command sampled on edge N
// owns the data cycle up to edge N+1: a read drives the array output during
// it, and a write stores din at edge N+1 with the lanes of that command.
// Assumes seq_linear is held steady for the length of a burst.
module ftzt_sram
    import ftzt_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             burst_adv,
    input  logic             is_write,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_wen,
    input  logic             seq_linear,
    input  logic             drive_ok,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_oe
);

    logic              selected;
    logic              pend_v;
    op_e               pend_op;
    logic              pend_is_wr;
    logic [AW-1:0]     base;
    logic [BEAT_W-1:0] beat;
    logic [LANES-1:0]  lanes;
    logic [AW-1:0]     eff_addr;
    logic              arr_wr;

    // Purpose: decode the three chip selects.
    always_comb selected = !cs0_n && cs1 && !cs2_n;

    ftzt_cmd_reg #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .selected (selected),
        .burst_adv(burst_adv),
        .is_write (is_write),
        .addr     (addr),
        .lane_wen (lane_wen),
        .pend_v   (pend_v),
        .pend_op  (pend_op),
        .base     (base),
        .beat     (beat),
        .lanes    (lanes)
    );

    ftzt_addr_gen #(.AW(AW)) u_agen (
        .base      (base),
        .beat      (beat),
        .seq_linear(seq_linear),
        .eff_addr  (eff_addr)
    );

    // Purpose: write on the enabled edge that closes a pending write cycle.
    always_comb begin
        pend_is_wr = (pend_op == OP_WR);
        arr_wr     = !clk_en_n && pend_v && pend_is_wr;
    end

    ftzt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk      (clk),
        .wr_en    (arr_wr),
        .word_addr(eff_addr),
        .lane_mask(lanes),
        .wdata    (din),
        .rdata    (dout)
    );

    // Purpose: drive the bus during a read cycle unless output enable is off.
    always_comb dout_oe = pend_v && !pend_is_wr && drive_ok;

endmodule

// File: rtl/ftzt_sram_chk.sv
// Checker for ftzt_sram: timing properties of the command and data cycles.
// Attached to every instance of the top module by the bind below.
module ftzt_sram_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          cs0_n,
    input logic          cs1,
    input logic          cs2_n,
    input logic          burst_adv,
    input logic          is_write,
    input logic          drive_ok,
    input logic          dout_oe,
    input logic          pend_v,
    input logic          pend_wr,
    input logic [1:0]    beat,
    input logic [AW-1:0] eff_addr
);

    logic sel_in;
    assign sel_in = !cs0_n && cs1 && !cs2_n;

    // R3: a stalled edge changes no state.
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(pend_v) && $stable(pend_wr) && $stable(beat) && $stable(eff_addr)));

    // R4 / R5: a deselecting load leaves the bus undriven in the next cycle.
    p_desel_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_adv && !sel_in) |=> (!pend_v && !dout_oe));

    // R5: a sampled write command leaves the bus undriven in the next cycle.
    p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_adv && sel_in && is_write) |=> !dout_oe);

    // R1: a sampled read drives the bus in the next cycle when allowed.
    p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_adv && sel_in && !is_write) |=> (dout_oe == drive_ok));

    // R6: an advance steps the beat and keeps the operation type.
    p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && burst_adv && pend_v) |=>
            (pend_v && (beat == 2'($past(beat) + 2'd1)) && (pend_wr == $past(pend_wr))));

    // R10: output enable off means no drive.
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_ok |-> !dout_oe);

    // R11: reset leaves nothing pending.
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> !pend_v);

endmodule

bind ftzt_sram ftzt_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .cs0_n    (cs0_n),
    .cs1      (cs1),
    .cs2_n    (cs2_n),
    .burst_adv(burst_adv),
    .is_write (is_write),
    .drive_ok (drive_ok),
    .dout_oe  (dout_oe),
    .pend_v   (pend_v),
    .pend_wr  (pend_is_wr),
    .beat     (beat),
    .eff_addr (eff_addr)
);

// File: tb/tb_ftzt_sram.sv
// Directed bench for ftzt_sram. Commands are applied at the falling edge.
// The outputs are checked at the next falling edge, in the data cycle of the
// command sampled at the rising edge in between. A reference memory and a
// pending-command record are kept from the requirements alone.
module tb_ftzt_sram;

    localparam int DEPTH  = 256;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int AW     = 8;
    localparam int DW     = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en_n = 1'b0;
    logic             cs0_n = 1'b1;
    logic             cs1 = 1'b1;
    logic             cs2_n = 1'b0;
    logic             burst_adv = 1'b0;
    logic             is_write = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [LANES-1:0] lane_wen = '1;
    logic             seq_linear = 1'b1;
    logic             drive_ok = 1'b1;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_oe;

    ftzt_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .burst_adv(burst_adv), .is_write(is_write), .addr(addr),
        .lane_wen(lane_wen), .seq_linear(seq_linear), .drive_ok(drive_ok),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    int wseq   = 0;

    // next command, copied onto the pins at the falling edge
    logic             n_rst = 1'b0, n_en_n = 1'b0, n_c0n = 1'b1, n_c1 = 1'b1, n_c2n = 1'b0;
    logic             n_adv = 1'b0, n_wr = 1'b0, n_ok = 1'b1;
    logic [AW-1:0]    n_addr = '0;
    logic [LANES-1:0] n_lanes = '1;

    // reference state
    logic [DW-1:0]    ref_mem [DEPTH];
    logic             m_v = 1'b0, m_wr = 1'b0;
    logic [AW-1:0]    m_base = '0;
    logic [1:0]       m_beat = '0;
    logic [LANES-1:0] m_lanes = '0;
    string            m_tag = "R11 reset";

    function automatic logic [DW-1:0] mkdata(input int k);
        logic [DW-1:0] w;
        for (int l = 0; l < LANES; l++) w[l*LANE_W +: LANE_W] = LANE_W'(k * 7 + l * 61 + 3);
        return w;
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] k,
                                                 input logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + k) : (b[1:0] ^ k);
        return {b[AW-1:2], lo};
    endfunction

    task automatic fail_line(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        errors++;
        $display("FAIL %s: %s got %h expected %h", m_tag, what, got, exp);
    endtask

    // One cycle: check the current data cycle, apply the next command, model the edge.
    task automatic tick(input string tag);
        logic          exp_oe;
        logic [AW-1:0] ea;
        @(negedge clk);
        ea     = beat_addr(m_base, m_beat, seq_linear);
        exp_oe = m_v && !m_wr && drive_ok;
        checks++;
        if (dout_oe !== exp_oe) fail_line("dout_oe", DW'(dout_oe), DW'(exp_oe));
        if (exp_oe) begin
            checks++;
            if (dout !== ref_mem[ea]) fail_line("dout", dout, ref_mem[ea]);
        end
        rst_n = n_rst; clk_en_n = n_en_n; cs0_n = n_c0n; cs1 = n_c1; cs2_n = n_c2n;
        burst_adv = n_adv; is_write = n_wr; addr = n_addr; lane_wen = n_lanes;
        drive_ok = n_ok;
        wseq++;
        din = mkdata(wseq);
        @(posedge clk);
        #1;
        m_tag = tag;
        if (!rst_n) begin
            m_v = 1'b0;
        end else if (!clk_en_n) begin
            if (m_v && m_wr) begin
                for (int l = 0; l < LANES; l++)
                    if (m_lanes[l]) ref_mem[ea][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
            end
            if (!burst_adv) begin
                if (!cs0_n && cs1 && !cs2_n) begin
                    m_v = 1'b1; m_wr = is_write; m_base = addr; m_beat = 2'd0; m_lanes = lane_wen;
                end else begin
                    m_v = 1'b0;
                end
            end else if (m_v) begin
                m_beat  = m_beat + 2'd1;
                m_lanes = lane_wen;
            end
        end
    endtask

    task automatic set_load(input logic wr, input logic [AW-1:0] a, input logic [LANES-1:0] ln);
        n_en_n = 1'b0; n_adv = 1'b0; n_c0n = 1'b0; n_c1 = 1'b1; n_c2n = 1'b0;
        n_wr = wr; n_addr = a; n_lanes = ln;
    endtask

    task automatic set_adv(input logic [LANES-1:0] ln);
        n_en_n = 1'b0; n_adv = 1'b1; n_lanes = ln;
    endtask

    task automatic set_desel(input int which, input logic wr, input logic [AW-1:0] a);
        set_load(wr, a, '1);
        if (which == 0) n_c0n = 1'b1;
        else if (which == 1) n_c1 = 1'b0;
        else n_c2n = 1'b1;
    endtask

    task automatic t_reset();
        n_rst = 1'b0;
        set_load(1'b0, 8'h00, '1);
        for (int i = 0; i < 3; i++) tick("R11 reset idle");
        n_rst = 1'b1;
        set_desel(0, 1'b0, 8'h00);
        tick("R11 after reset");
        tick("R11 after reset");
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            set_load(1'b1, AW'(i), '1);
            tick("R1 fill write");
        end
        set_desel(0, 1'b0, 8'h00);
        tick("R5 deselect after fill");
    endtask

    task automatic t_alternate();
        set_load(1'b1, 8'h10, '1); tick("R5 write start");
        set_load(1'b0, 8'h10, '1); tick("R2 read after write");
        set_load(1'b1, 8'h11, '1); tick("R2 write after read");
        set_load(1'b0, 8'h11, '1); tick("R1 read");
        set_load(1'b0, 8'h10, '1); tick("R1 read back-to-back");
        set_load(1'b1, 8'h10, '1); tick("R5 write start");
        set_desel(0, 1'b0, 8'h00); tick("R5 deselect");
        tick("R5 deselect");
    endtask

    task automatic t_burst(input logic lin, input int off);
        logic [AW-1:0] g;
        string         tg;
        g  = AW'(8'h40 + (lin ? 0 : 8'h20) + off * 4);
        tg = lin ? "R7 linear burst" : "R8 interleaved burst";
        seq_linear = lin;
        set_load(1'b1, g + AW'(off), '1); tick(tg);
        for (int k = 0; k < 3; k++) begin set_adv('1); tick("R6 write advance"); end
        set_load(1'b0, g + AW'(off), '1); tick(tg);
        for (int k = 0; k < 3; k++) begin set_adv('1); tick(tg); end
        for (int k = 0; k < 4; k++) begin set_load(1'b0, g + AW'(k), '1); tick(tg); end
        set_desel(0, 1'b0, 8'h00); tick("R5 deselect");
    endtask

    task automatic t_stall();
        seq_linear = 1'b1;
        set_load(1'b0, 8'h41, '1); tick("R1 read burst");
        set_adv('1); tick("R6 read advance");
        n_en_n = 1'b1; n_adv = 1'b0; n_wr = 1'b1; n_addr = 8'hF0;
        tick("R3 stall mid-burst");
        tick("R3 stall mid-burst");
        set_adv('1); tick("R6 resume");
        set_adv('1); tick("R6 resume");
        set_load(1'b1, 8'h90, '1); tick("R3 write then stall");
        n_en_n = 1'b1; n_c0n = 1'b1; tick("R3 stalled write cycle");
        set_desel(0, 1'b0, 8'h00); tick("R4 write completes");
        set_load(1'b0, 8'h90, '1); tick("R3 read stalled write");
        set_desel(0, 1'b0, 8'h00); tick("R5 deselect");
    endtask

    task automatic t_deselect();
        set_load(1'b1, 8'hA0, '1); tick("R4 write before deselect");
        set_desel(0, 1'b1, 8'hA0); tick("R4 pending write completes");
        set_desel(1, 1'b1, 8'hA1); tick("R4 cs1 inactive write ignored");
        set_desel(2, 1'b1, 8'hA2); tick("R4 cs2_n inactive write ignored");
        set_desel(0, 1'b1, 8'hA3); tick("R4 cs0_n inactive write ignored");
        set_adv('1); tick("R4 advance while idle");
        for (int k = 0; k < 4; k++) begin
            set_load(1'b0, AW'(8'hA0 + k), '1); tick("R4 readback");
        end
        set_load(1'b0, 8'hA0, '1); tick("R4 read then deselect");
        set_desel(1, 1'b0, 8'h00); tick("R5 deselect after read");
        set_desel(0, 1'b0, 8'h00); tick("R5 idle");
    endtask

    task automatic t_lanes();
        set_load(1'b1, 8'hB0, 4'b0101); tick("R9 partial lanes");
        set_load(1'b1, 8'hB1, 4'b1000); tick("R9 top lane");
        set_load(1'b0, 8'hB0, '1); tick("R9 read lanes");
        set_load(1'b0, 8'hB1, '1); tick("R9 read lanes");
        seq_linear = 1'b1;
        set_load(1'b1, 8'hB4, 4'b0011); tick("R9 burst lanes");
        set_adv(4'b1100); tick("R9 burst lanes");
        set_load(1'b0, 8'hB4, '1); tick("R9 read lanes");
        set_load(1'b0, 8'hB5, '1); tick("R9 read lanes");
        set_desel(0, 1'b0, 8'h00); tick("R5 deselect");
    endtask

    task automatic t_oe();
        set_load(1'b0, 8'h12, '1); tick("R10 read for output enable");
        set_desel(0, 1'b0, 8'h00);
        // mid-cycle: the read data cycle is active now
        drive_ok = 1'b0; #2;
        checks++;
        if (dout_oe !== 1'b0) begin errors++; $display("FAIL R10: dout_oe got %b expected 0", dout_oe); end
        drive_ok = 1'b1; #2;
        checks++;
        if (dout_oe !== 1'b1) begin errors++; $display("FAIL R10: dout_oe got %b expected 1", dout_oe); end
        tick("R5 deselect");
        set_load(1'b0, 8'h12, '1); n_ok = 1'b0; tick("R10 output enable off");
        n_ok = 1'b1; set_desel(0, 1'b0, 8'h00); tick("R5 deselect");
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_alternate();
        for (int lin = 1; lin >= 0; lin--)
            for (int off = 0; off < 4; off++) t_burst(1'(lin), off);
        t_stall();
        t_deselect();
        t_lanes();
        t_oe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule